// File: doc/BRIEF.md
# Clockless Two-Master Shared-Bus Arbiter

This block lets two bus masters, called A and B, share one group of slaves on a Wishbone-style bus. Each master treats the shared group as one more slave on its own local response chain. The shared slaves see a single master.

Only the handshake lines pass through the block: cycle, strobe and write enable go out, and acknowledge, retry and error come back. The address, data and byte-select buses are steered by multiplexers outside the block, driven from the `sel_b_o` output.

There is no clock. Ownership is held in a reset-cleared, level-sensitive set/reset element. Every other output is combinational, so a shared slave may answer in the same cycle that the strobe appears. Retry and error from the shared bus refer to the last access of the owner's current block.

Each master port also takes the acknowledge, retry and error chain from its own local slaves. These are merged by OR into the responses the block returns to that master.

Top module: `arb2_bus_share`

## Requirements
- R1: While `rst_i` is high, neither master owns the bus: all three shared request outputs and `sel_b_o` are 0. After `rst_i` falls, a master still holding its cycle line is granted again under the normal rules.
- R2: With the bus free, a master that raises its cycle line alone becomes owner at once, with no clock edge needed.
- R3: If both cycle lines are high while the bus is free, master A becomes owner.
- R4: The owner keeps the bus for as long as its cycle line stays high. Strobe gaps and requests from the other master do not change this. The other master can take over only after the owner drops its cycle line.
- R5: `s_cyc_o`, `s_stb_o` and `s_we_o` copy the owner's cycle, strobe and write enable. All three are 0 when there is no owner.
- R6: `sel_b_o` is 1 exactly when master B owns the bus. It is 0 otherwise, which selects A's address and data lines.
- R7: A shared acknowledge, retry or error reaches only the owner's matching output, through combinational logic only. The master that does not own the bus gets nothing from the shared bus.
- R8: Each master's acknowledge, retry and error output is the OR of its own chain input and the shared response routed to it. This holds whether or not that master owns the bus.
- R9: The two masters never own the bus at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_i | input | 1 | Active-high reset; clears ownership |
| a_cyc_i | input | 1 | Master A cycle frame |
| a_stb_i | input | 1 | Master A strobe |
| a_we_i | input | 1 | Master A write enable |
| a_ack_chain_i | input | 1 | Master A local acknowledge chain |
| a_rty_chain_i | input | 1 | Master A local retry chain |
| a_err_chain_i | input | 1 | Master A local error chain |
| a_ack_o | output | 1 | Acknowledge to master A |
| a_rty_o | output | 1 | Retry to master A |
| a_err_o | output | 1 | Error to master A |
| b_cyc_i | input | 1 | Master B cycle frame |
| b_stb_i | input | 1 | Master B strobe |
| b_we_i | input | 1 | Master B write enable |
| b_ack_chain_i | input | 1 | Master B local acknowledge chain |
| b_rty_chain_i | input | 1 | Master B local retry chain |
| b_err_chain_i | input | 1 | Master B local error chain |
| b_ack_o | output | 1 | Acknowledge to master B |
| b_rty_o | output | 1 | Retry to master B |
| b_err_o | output | 1 | Error to master B |
| s_cyc_o | output | 1 | Shared bus cycle frame |
| s_stb_o | output | 1 | Shared bus strobe |
| s_we_o | output | 1 | Shared bus write enable |
| s_ack_i | input | 1 | Shared bus acknowledge |
| s_rty_i | input | 1 | Shared bus retry |
| s_err_i | input | 1 | Shared bus error |
| sel_b_o | output | 1 | External mux select: 1 passes master B's lines |

## Verification
Two paths can act in the same cycle:
- the shared-bus response routed to the owner, and
- the local chain response passed to the master that does not own the bus.

This is provoked by holding master A as owner while it receives a shared acknowledge, and at the same time giving master B a chain acknowledge. Both acknowledge outputs must then be high together. B's output must show no sign of the shared response when B's chain input is low.

A second overlap is a master's own chain and the shared response arriving on the same line together. Each vector is applied and the outputs are sampled within the same half period, which shows that no clock edge lies on the response path.

// File: rtl/arb2_pkg.sv
package arb2_pkg;
  localparam int unsigned NPORT  = 2;
  localparam int unsigned PORT_A = 0;
  localparam int unsigned PORT_B = 1;

  typedef struct packed {
    logic cyc;
    logic stb;
    logic we;
  } req_t;

  typedef struct packed {
    logic ack;
    logic rty;
    logic err;
  } resp_t;
endpackage

// File: rtl/arb2_owner_hold.sv
module arb2_owner_hold (
  input  logic rst_i,
  input  logic a_cyc_i,
  input  logic b_cyc_i,
  output logic own_a_o,
  output logic own_b_o
);
  // Set/reset hold for master A: released when A drops its cycle,
  // set only while B does not hold the bus.
  always_latch begin
    if (rst_i)         own_a_o <= 1'b0;
    else if (!a_cyc_i) own_a_o <= 1'b0;
    else if (!own_b_o) own_a_o <= 1'b1;
  end

  // Set/reset hold for master B: set only when A neither owns nor asks,
  // which gives A the win on a simultaneous request.
  always_latch begin
    if (rst_i)                      own_b_o <= 1'b0;
    else if (!b_cyc_i)              own_b_o <= 1'b0;
    else if (!own_a_o && !a_cyc_i)  own_b_o <= 1'b1;
  end

  always_comb begin
    // R9
    no_dual_owner_chk: assert final (!(own_a_o && own_b_o))
      else $error("both masters hold the bus");
    // R1
    reset_clears_chk: assert final (!rst_i || (!own_a_o && !own_b_o))
      else $error("ownership present during reset");
  end
endmodule

// File: rtl/arb2_req_gate.sv
module arb2_req_gate
  import arb2_pkg::*;
(
  input  req_t a_req_i,
  input  req_t b_req_i,
  input  logic own_a_i,
  input  logic own_b_i,
  output req_t s_req_o,
  output logic sel_b_o
);
  always_comb begin
    if (own_a_i)      s_req_o = a_req_i;
    else if (own_b_i) s_req_o = b_req_i;
    else              s_req_o = '0;
  end

  assign sel_b_o = own_b_i;

  always_comb begin
    // R5
    shared_cyc_source_chk: assert final (!s_req_o.cyc || a_req_i.cyc || b_req_i.cyc)
      else $error("shared cycle without any master cycle");
  end
endmodule

// File: rtl/arb2_resp_route.sv
module arb2_resp_route
  import arb2_pkg::*;
#(
  parameter int unsigned PORTS = NPORT
) (
  input  resp_t              s_rsp_i,
  input  logic [PORTS-1:0]   own_i,
  input  resp_t [PORTS-1:0]  chain_i,
  output resp_t [PORTS-1:0]  rsp_o
);
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    resp_t routed;
    assign routed   = own_i[p] ? s_rsp_i : '0;
    assign rsp_o[p] = routed | chain_i[p];

    always_comb begin
      // R7
      no_leak_chk: assert final (own_i[p] || (rsp_o[p] == chain_i[p]))
        else $error("shared response leaked to a non-owner");
    end
  end
endmodule

// File: rtl/arb2_bus_share.sv
module arb2_bus_share
  import arb2_pkg::*;
(
  input  logic rst_i,
  input  logic a_cyc_i,
  input  logic a_stb_i,
  input  logic a_we_i,
  input  logic a_ack_chain_i,
  input  logic a_rty_chain_i,
  input  logic a_err_chain_i,
  output logic a_ack_o,
  output logic a_rty_o,
  output logic a_err_o,
  input  logic b_cyc_i,
  input  logic b_stb_i,
  input  logic b_we_i,
  input  logic b_ack_chain_i,
  input  logic b_rty_chain_i,
  input  logic b_err_chain_i,
  output logic b_ack_o,
  output logic b_rty_o,
  output logic b_err_o,
  output logic s_cyc_o,
  output logic s_stb_o,
  output logic s_we_o,
  input  logic s_ack_i,
  input  logic s_rty_i,
  input  logic s_err_i,
  output logic sel_b_o
);
  logic own_a, own_b;
  req_t a_req, b_req, s_req;
  resp_t s_rsp;
  resp_t [NPORT-1:0] chain, rsp;
  logic  [NPORT-1:0] own_vec;

  assign a_req = '{cyc: a_cyc_i, stb: a_stb_i, we: a_we_i};
  assign b_req = '{cyc: b_cyc_i, stb: b_stb_i, we: b_we_i};
  assign s_rsp = '{ack: s_ack_i, rty: s_rty_i, err: s_err_i};
  assign chain[PORT_A] = '{ack: a_ack_chain_i, rty: a_rty_chain_i, err: a_err_chain_i};
  assign chain[PORT_B] = '{ack: b_ack_chain_i, rty: b_rty_chain_i, err: b_err_chain_i};
  assign own_vec[PORT_A] = own_a;
  assign own_vec[PORT_B] = own_b;

  arb2_owner_hold u_hold (
    .rst_i   (rst_i),
    .a_cyc_i (a_cyc_i),
    .b_cyc_i (b_cyc_i),
    .own_a_o (own_a),
    .own_b_o (own_b)
  );

  arb2_req_gate u_gate (
    .a_req_i (a_req),
    .b_req_i (b_req),
    .own_a_i (own_a),
    .own_b_i (own_b),
    .s_req_o (s_req),
    .sel_b_o (sel_b_o)
  );

  arb2_resp_route #(.PORTS(NPORT)) u_route (
    .s_rsp_i (s_rsp),
    .own_i   (own_vec),
    .chain_i (chain),
    .rsp_o   (rsp)
  );

  assign s_cyc_o = s_req.cyc;
  assign s_stb_o = s_req.stb;
  assign s_we_o  = s_req.we;
  assign a_ack_o = rsp[PORT_A].ack;
  assign a_rty_o = rsp[PORT_A].rty;
  assign a_err_o = rsp[PORT_A].err;
  assign b_ack_o = rsp[PORT_B].ack;
  assign b_rty_o = rsp[PORT_B].rty;
  assign b_err_o = rsp[PORT_B].err;

  always_comb begin
    // R6
    sel_needs_b_cyc_chk: assert final (!sel_b_o || b_cyc_i)
      else $error("select points at B while B has no cycle");
  end
endmodule

// File: tb/arb2_bus_share_bench.sv
`timescale 1ns/1ps
module arb2_bus_share_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_i;
  logic a_cyc_i, a_stb_i, a_we_i, a_ack_chain_i, a_rty_chain_i, a_err_chain_i;
  logic b_cyc_i, b_stb_i, b_we_i, b_ack_chain_i, b_rty_chain_i, b_err_chain_i;
  logic s_ack_i, s_rty_i, s_err_i;
  logic a_ack_o, a_rty_o, a_err_o, b_ack_o, b_rty_o, b_err_o;
  logic s_cyc_o, s_stb_o, s_we_o, sel_b_o;

  arb2_bus_share u_arb2_bus_share (
    .rst_i(rst_i),
    .a_cyc_i(a_cyc_i), .a_stb_i(a_stb_i), .a_we_i(a_we_i),
    .a_ack_chain_i(a_ack_chain_i), .a_rty_chain_i(a_rty_chain_i), .a_err_chain_i(a_err_chain_i),
    .a_ack_o(a_ack_o), .a_rty_o(a_rty_o), .a_err_o(a_err_o),
    .b_cyc_i(b_cyc_i), .b_stb_i(b_stb_i), .b_we_i(b_we_i),
    .b_ack_chain_i(b_ack_chain_i), .b_rty_chain_i(b_rty_chain_i), .b_err_chain_i(b_err_chain_i),
    .b_ack_o(b_ack_o), .b_rty_o(b_rty_o), .b_err_o(b_err_o),
    .s_cyc_o(s_cyc_o), .s_stb_o(s_stb_o), .s_we_o(s_we_o),
    .s_ack_i(s_ack_i), .s_rty_i(s_rty_i), .s_err_i(s_err_i),
    .sel_b_o(sel_b_o)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // input  {rst, a cyc/stb/we, b cyc/stb/we, shared ack/rty/err, a chain, b chain}
  // expect {shared cyc/stb/we, sel_b, a ack/rty/err, b ack/rty/err}
  localparam int NV = 20;
  localparam logic [15:0] VIN [NV] = '{
    16'b1_110_100_000_000_000, // R1 reset with requests pending
    16'b0_000_000_000_000_000, // R5 idle
    16'b0_111_000_000_000_000, // R2 A alone
    16'b0_111_000_100_000_000, // R7 ack to owner A
    16'b0_101_110_000_000_000, // R4 A strobe gap, B asks
    16'b0_110_110_100_000_000, // R7 ack not seen by B
    16'b0_000_110_000_000_000, // R4 A drops, B takes over
    16'b0_000_110_010_000_000, // R7 retry to owner B
    16'b0_110_110_001_000_000, // R7 error to B, A waits
    16'b0_110_000_000_000_000, // R4 B drops, waiting A granted
    16'b0_000_000_000_000_000, // R5 idle again
    16'b0_111_110_000_000_000, // R3 simultaneous request
    16'b0_111_110_000_010_101, // R8 chains to both masters
    16'b0_111_110_100_000_100, // R7 R8 shared ack and B chain together
    16'b0_111_110_100_100_000, // R8 owner chain plus shared ack
    16'b0_000_000_000_000_100, // R8 chain with no owner
    16'b0_000_111_000_000_000, // R6 B alone
    16'b1_000_111_000_000_000, // R1 reset drops B
    16'b0_000_111_000_000_000, // R1 B regranted after reset
    16'b0_000_111_001_000_000  // R7 error to B
  };
  localparam logic [9:0] VEXP [NV] = '{
    10'b000_0_000_000,
    10'b000_0_000_000,
    10'b111_0_000_000,
    10'b111_0_100_000,
    10'b101_0_000_000,
    10'b110_0_100_000,
    10'b110_1_000_000,
    10'b110_1_000_010,
    10'b110_1_000_001,
    10'b110_0_000_000,
    10'b000_0_000_000,
    10'b111_0_000_000,
    10'b111_0_010_101,
    10'b111_0_100_100,
    10'b111_0_100_000,
    10'b000_0_000_100,
    10'b111_1_000_000,
    10'b000_0_000_000,
    10'b111_1_000_000,
    10'b111_1_000_001
  };

  function automatic logic [9:0] outs();
    return {s_cyc_o, s_stb_o, s_we_o, sel_b_o, a_ack_o, a_rty_o, a_err_o,
            b_ack_o, b_rty_o, b_err_o};
  endfunction

  task automatic drive(input logic [15:0] v);
    {rst_i, a_cyc_i, a_stb_i, a_we_i, b_cyc_i, b_stb_i, b_we_i,
     s_ack_i, s_rty_i, s_err_i, a_ack_chain_i, a_rty_chain_i, a_err_chain_i,
     b_ack_chain_i, b_rty_chain_i, b_err_chain_i} = v;
  endtask

  task automatic check(input logic [9:0] got, input logic [9:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b expected=%b", tag, got, exp);
    end
  endtask

  function automatic string field_tag(input logic [9:0] got, input logic [9:0] exp);
    if (got[9:7] !== exp[9:7]) return "R5 shared request";
    if (got[6]   !== exp[6])   return "R6 select";
    return "R7/R8 responses";
  endfunction

  initial begin
    drive('0);
    rst_i = 1'b1;
    @(posedge clk);
    for (int i = 0; i < NV; i++) begin
      #1 drive(VIN[i]);
      @(negedge clk);
      check(outs(), VEXP[i], $sformatf("%s vec %0d", field_tag(outs(), VEXP[i]), i));
      @(posedge clk);
    end

    // R4: A owns; B toggles its cycle and A pauses its strobe; ownership stays
    #1 drive(16'b0_111_000_000_000_000);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      b_cyc_i = ~b_cyc_i; b_stb_i = b_cyc_i; a_stb_i = ~a_stb_i;
      @(negedge clk);
      check({s_cyc_o, sel_b_o}, 2'b10, "R4 held across B toggles");
    end

    // R1 then R3: reset while both request, release selects A
    @(posedge clk); #1 drive(16'b1_111_111_000_000_000);
    @(negedge clk);
    check({s_cyc_o, s_stb_o, s_we_o, sel_b_o}, 4'b0000, "R1 reset with both asking");
    @(posedge clk); #1 rst_i = 1'b0;
    @(negedge clk);
    check({s_cyc_o, sel_b_o}, 2'b10, "R3 A wins after reset");

    // R7: zero-delay response; sample 0.1 ns after shared ack rises
    @(posedge clk); #1 s_ack_i = 1'b1;
    #0.1;
    check({a_ack_o, b_ack_o}, 2'b10, "R7 same-instant ack to owner");
    s_ack_i = 1'b0;

    // R2 R6: A drops, B granted without any edge
    #0.5 a_cyc_i = 1'b0; a_stb_i = 1'b0;
    #0.1;
    check({s_cyc_o, s_we_o, sel_b_o}, 3'b111, "R2 R6 handover to B");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 got=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule